// File: doc/BRIEF.md
# Shift-and-Select Unsigned Multiplier

This block multiplies two unsigned operands of a parameterized width and returns the full double-width product. It uses the halving and doubling method. The multiplicand passes down a chain of one-bit left shifts and the multiplier passes down a matching chain of one-bit right shifts, with one stage per multiplier bit. At each stage a 2:1 selector passes either the doubled multiplicand or zero as that stage's partial product. The selector is steered by the lowest bit of the halved multiplier at that stage.

The partial products are zero-extended to the product width. A 3:2 carry-save tree compresses them to two rows, and a parallel-prefix adder merges those two rows into the product. The block is meant to be dropped into a filter tap or any datapath that needs an exact unsigned product. An optional output register, present by default, gives one cycle of latency. When it is removed the block is purely combinational.

Top module: `peasant_mult`

## Requirements
- R1: With the output register present, `product` equals the exact unsigned product of the `op_a` and `op_b` values sampled at the previous rising clock edge, for every operand pair.
- R2: When either operand is zero, the product is zero.
- R3: When both operands are all ones, the product is (2^WIDTH - 1)^2; for WIDTH=8 this is 16'hFE01.
- R4: When `op_b` is 1, the product equals `op_a` zero-extended to 2*WIDTH bits.
- R5: When `op_b` is 2^k, the product equals `op_a` shifted left by k. Only the stage whose halved-multiplier lowest bit is set contributes to the sum.
- R6: While `rst` is high at a rising clock edge, the registered product becomes zero on that edge, whatever the operands are.
- R7: While the operands stay unchanged, the registered product stays unchanged.
- R8: With OUT_REG=0, `product` follows the operands within the same cycle and equals their exact unsigned product.
- R9: With WIDTH=16, the product is exact for arbitrary operand pairs and for the corner values 0, 1 and 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | Multiplicand, shifted left stage by stage |
| op_b | input | WIDTH | Multiplier, shifted right stage by stage; its low bits steer the selectors |
| product | output | 2*WIDTH | Unsigned product, registered when OUT_REG=1 |

## Verification
The hardest condition to reach from the ports is one where every carry-save level emits carries that ripple across the whole width of the final prefix adder, with all selectors active at once. Only operand pairs near all ones in both inputs bring this about, so it is easy to miss. At WIDTH=8 the bench reaches it by sweeping all 65,536 operand pairs, which also covers every selector pattern. At WIDTH=16 it drives the all-ones corner directly alongside random pairs. The sweep runs through a registered and a combinational instance that share the same inputs, so both output paths are compared in every cycle.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Rows left after one 3:2 compression level applied to n rows.
  function automatic int pm_next_rows(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Rows present at the input of compression level lvl.
  function automatic int pm_rows_at(input int n, input int lvl);
    int r;
    r = n;
    for (int i = 0; i < lvl; i++) r = pm_next_rows(r);
    return r;
  endfunction

  // Number of 3:2 levels needed to bring n rows down to two.
  function automatic int pm_csa_levels(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = pm_next_rows(r);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/pm_pp_gen.sv
module pm_pp_gen #(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0]           mcand,
  input  logic [WIDTH-1:0]           mplier,
  output logic [WIDTH-1:0][PW-1:0]   pp
);

  // Doubling chain and halving chain, one stage per multiplier bit.
  logic [WIDTH-1:0][PW-1:0]    dbl;
  logic [WIDTH-1:0][WIDTH-1:0] hlf;

  assign dbl[0] = {{WIDTH{1'b0}}, mcand};
  assign hlf[0] = mplier;

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_chain
      assign dbl[i] = {dbl[i-1][PW-2:0], 1'b0};
      assign hlf[i] = {1'b0, hlf[i-1][WIDTH-1:1]};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_sel
      // The halved multiplier's lowest bit steers the 2:1 selector.
      assign pp[i] = hlf[i][0] ? dbl[i] : '0;
    end
  endgenerate

endmodule

// File: rtl/pm_csa_tree.sv
module pm_csa_tree
  import pm_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int PW   = 16
) (
  input  logic [ROWS-1:0][PW-1:0] rows_in,
  output logic [PW-1:0]           sum_row,
  output logic [PW-1:0]           carry_row
);

  localparam int LEVELS = pm_csa_levels(ROWS);

  logic [PW-1:0] lvl [LEVELS+1][ROWS];

  generate
    for (genvar j = 0; j < ROWS; j++) begin : g_in
      assign lvl[0][j] = rows_in[j];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int NIN  = pm_rows_at(ROWS, l);
      localparam int GRP  = NIN / 3;
      localparam int NOUT = pm_next_rows(NIN);
      for (genvar j = 0; j < ROWS; j++) begin : g_row
        if (j < 2 * GRP) begin : g_csa
          localparam int K = j / 2;
          if (j % 2 == 0) begin : g_sum
            assign lvl[l+1][j] = lvl[l][3*K] ^ lvl[l][3*K+1] ^ lvl[l][3*K+2];
          end else begin : g_cy
            // The top bit shifted out is always zero, because the total stays below 2^PW.
            assign lvl[l+1][j] = ((lvl[l][3*K] & lvl[l][3*K+1]) |
                                  (lvl[l][3*K] & lvl[l][3*K+2]) |
                                  (lvl[l][3*K+1] & lvl[l][3*K+2])) << 1;
          end
        end else if (j < NOUT) begin : g_pass
          assign lvl[l+1][j] = lvl[l][3*GRP + (j - 2*GRP)];
        end else begin : g_idle
          assign lvl[l+1][j] = '0;
        end
      end
    end
  endgenerate

  assign sum_row   = lvl[LEVELS][0];
  assign carry_row = lvl[LEVELS][1];

endmodule

// File: rtl/pm_prefix_adder.sv
module pm_prefix_adder #(
  parameter int W = 16,
  localparam int LOG = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic [W-1:0] sum
);

  logic [W-1:0] gen [LOG+1];
  logic [W-1:0] prp [LOG+1];

  assign gen[0] = in_x & in_y;
  assign prp[0] = in_x ^ in_y;

  generate
    for (genvar s = 0; s < LOG; s++) begin : g_stage
      for (genvar i = 0; i < W; i++) begin : g_bit
        if (((i >> s) & 1) == 1) begin : g_merge
          // Each node merges with the last bit of the block just below it.
          localparam int SRC = ((i >> s) << s) - 1;
          assign gen[s+1][i] = gen[s][i] | (prp[s][i] & gen[s][SRC]);
          assign prp[s+1][i] = prp[s][i] & prp[s][SRC];
        end else begin : g_keep
          assign gen[s+1][i] = gen[s][i];
          assign prp[s+1][i] = prp[s][i];
        end
      end
    end
  endgenerate

  assign sum = prp[0] ^ {gen[LOG][W-2:0], 1'b0};

endmodule

// File: rtl/peasant_mult.sv
module peasant_mult #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [PW-1:0]    product
);

  logic [WIDTH-1:0][PW-1:0] pp;
  logic [PW-1:0]            row_s;
  logic [PW-1:0]            row_c;
  logic [PW-1:0]            prod_c;

  pm_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .mcand  (op_a),
    .mplier (op_b),
    .pp     (pp)
  );

  pm_csa_tree #(.ROWS(WIDTH), .PW(PW)) u_tree (
    .rows_in   (pp),
    .sum_row   (row_s),
    .carry_row (row_c)
  );

  pm_prefix_adder #(.W(PW)) u_add (
    .in_x (row_s),
    .in_y (row_c),
    .sum  (prod_c)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk) begin
        if (rst) prod_q <= '0;
        else     prod_q <= prod_c;
      end
      assign product = prod_q;
    end else begin : g_comb
      assign product = prod_c;
    end
  endgenerate

endmodule

// File: rtl/peasant_mult_chk.sv
module peasant_mult_chk #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int PW = 2 * WIDTH
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [PW-1:0]    product
);

  logic [1:0]    run_cnt;
  logic [PW-1:0] ref_prod;
  logic [PW-1:0] a_ext;

  assign a_ext    = {{WIDTH{1'b0}}, op_a};
  assign ref_prod = a_ext * {{WIDTH{1'b0}}, op_b};

  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  generate
    if (OUT_REG) begin : g_reg
      a_r1_exact: assert property (@(posedge clk) disable iff (rst)
        (run_cnt != 2'd0) |-> (product == $past(ref_prod)));
      a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
        ((run_cnt != 2'd0) && $past(op_a == '0 || op_b == '0)) |-> (product == '0));
      a_r4_unit_multiplier: assert property (@(posedge clk) disable iff (rst)
        ((run_cnt != 2'd0) && $past(op_b == WIDTH'(1))) |-> (product == $past(a_ext)));
      a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        ((run_cnt == 2'd3) && ($past(op_a) == $past(op_a, 2)) &&
         ($past(op_b) == $past(op_b, 2))) |-> $stable(product));
    end else begin : g_comb
      a_r8_exact: assert property (@(posedge clk) disable iff (rst)
        product == ref_prod);
      a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
        (op_a == '0 || op_b == '0) |-> (product == '0));
      a_r4_unit_multiplier: assert property (@(posedge clk) disable iff (rst)
        (op_b == WIDTH'(1)) |-> (product == a_ext));
      a_r8_follow: assert property (@(posedge clk) disable iff (rst)
        ($stable(op_a) && $stable(op_b)) |-> $stable(product));
    end
  endgenerate

endmodule

bind peasant_mult peasant_mult_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_a    (op_a),
  .op_b    (op_b),
  .product (product)
);

// File: tb/tb_peasant_mult.sv
`timescale 1ns/1ps
module tb_peasant_mult;

  localparam int TCK = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a8 = '0;
  logic [7:0]  b8 = '0;
  logic [15:0] a16 = '0;
  logic [15:0] b16 = '0;
  logic [15:0] p8;
  logic [15:0] p8c;
  logic [31:0] p16;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(TCK/2) clk = ~clk;

  peasant_mult #(.WIDTH(8), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .product(p8));

  peasant_mult #(.WIDTH(8), .OUT_REG(1'b0)) dut_c (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .product(p8c));

  peasant_mult #(.WIDTH(16), .OUT_REG(1'b1)) dut_w (
    .clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .product(p16));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drives 8-bit operands, checks the combinational
  // instance at once, then the registered instance at the next falling edge.
  task automatic apply8(input string tag, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] exp);
    a8 = a;
    b8 = b;
    #1;
    check("R8 comb", {16'h0, p8c}, {16'h0, exp});
    @(negedge clk);
    check(tag, {16'h0, p8}, {16'h0, exp});
  endtask

  task automatic apply16(input string tag, input logic [15:0] a, input logic [15:0] b);
    a16 = a;
    b16 = b;
    @(negedge clk);
    check(tag, p16, {16'h0, a} * {16'h0, b});
  endtask

  task automatic t_reset;
    rst = 1'b1;
    a8  = 8'hFF; b8 = 8'hFF; a16 = 16'hFFFF; b16 = 16'hFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R6 reset 8", {16'h0, p8}, 32'h0);
    check("R6 reset 16", p16, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_zero;
    apply8("R2 zero a", 8'h00, 8'hB7, 16'h0);
    apply8("R2 zero b", 8'hC3, 8'h00, 16'h0);
    apply8("R2 zero both", 8'h00, 8'h00, 16'h0);
  endtask

  task automatic t_ones;
    apply8("R3 all ones", 8'hFF, 8'hFF, 16'hFE01);
  endtask

  task automatic t_unit;
    apply8("R4 unit", 8'hA5, 8'h01, 16'h00A5);
    apply8("R4 unit max", 8'hFF, 8'h01, 16'h00FF);
  endtask

  task automatic t_pow2;
    for (int k = 0; k < 8; k++) begin
      apply8("R5 power of two", 8'hD9, 8'(1 << k), 16'(16'h00D9 << k));
    end
  endtask

  task automatic t_hold;
    apply8("R7 hold load", 8'h9C, 8'h6B, 16'h9C * 16'h6B);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check("R7 hold", {16'h0, p8}, 32'(16'h9C * 16'h6B));
    end
  endtask

  task automatic t_reset_mid;
    apply8("R1 before reset", 8'h77, 8'h88, 16'h77 * 16'h88);
    rst = 1'b1;
    @(negedge clk);
    check("R6 reset mid", {16'h0, p8}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after release", {16'h0, p8}, 32'(16'h77 * 16'h88));
  endtask

  task automatic t_exhaustive;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply8("R1 exhaustive", 8'(a), 8'(b), 16'(a) * 16'(b));
      end
    end
  endtask

  task automatic t_wide;
    apply16("R9 zero", 16'h0000, 16'hFFFF);
    apply16("R9 unit", 16'hBEEF, 16'h0001);
    apply16("R9 all ones", 16'hFFFF, 16'hFFFF);
    for (int n = 0; n < 2000; n++) begin
      apply16("R9 random", 16'($urandom), 16'($urandom));
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_zero();
    t_ones();
    t_unit();
    t_pow2();
    t_hold();
    t_reset_mid();
    t_wide();
    t_exhaustive();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule